// File: doc/BRIEF.md
# Interleaved SDR Transmit Interface for a Dual-Channel DAC

This block feeds a dual-channel DAC over one 12-bit data bus clocked at single data rate. Each sample period is two bus cycles long. The first cycle carries the I word and the second carries the Q word. A select line names the channel of the word now on the bus. The block divides the bus clock by two and exports the result as the sample clock for the user datapath. Once per sample period it raises a request strobe, and on that edge it takes one 16-bit I sample and one 16-bit Q sample. Only the upper 12 bits of each sample reach the bus.

Several instances can share one sync line, which one master instance drives. Each instance sends only zeros until it has seen that line high once after reset. From then on it keeps transmitting, and its enable outputs tell the datapath that it is live. While the underflow input is high on a capture edge, zeros replace the user sample for that whole period.

Top module: `dac_tx_if`

## Requirements
- R1: While reset is held and right after it, tx_data_o, tx_sel_o, smp_clk_o, i_req_o, q_req_o, i_en_o and q_en_o are all 0.
- R2: smp_clk_o changes level on every bus clock edge after reset, so its period is two bus cycles. It is 0 in the first cycle after reset.
- R3: tx_sel_o is 1 in each cycle that follows a cycle with smp_clk_o at 1, and 0 in each cycle that follows a cycle with smp_clk_o at 0. A value of 1 marks an I word and 0 marks a Q word.
- R4: Until sync_i has been sampled high on a clock edge after reset, i_en_o and q_en_o are 0, both request strobes are 0, and tx_data_o is 0, whatever the sample inputs hold.
- R5: The enables go high in the cycle after the edge that samples sync_i high. They then stay high no matter what sync_i does.
- R6: i_req_o and q_req_o are 1 exactly in the cycles where the enables are 1 and smp_clk_o is 1. The samples are taken on the edge that ends such a cycle.
- R7: In the cycle after a request edge, tx_data_o equals bits [15:4] of the I sample taken on that edge.
- R8: In the second cycle after a request edge, tx_data_o equals bits [15:4] of the Q sample taken on that edge, even if q_data_i has changed since.
- R9: When underflow_i is 1 on a request edge, tx_data_o is 0 in both of the following two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, twice the per-channel sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Shared transmit-start line |
| underflow_i | input | 1 | Upstream has no data; send zeros |
| i_data_i | input | 16 | I sample from the datapath |
| q_data_i | input | 16 | Q sample from the datapath |
| smp_clk_o | output | 1 | Divided sample clock |
| i_en_o | output | 1 | I channel live |
| q_en_o | output | 1 | Q channel live |
| i_req_o | output | 1 | I sample taken at the end of this cycle |
| q_req_o | output | 1 | Q sample taken at the end of this cycle |
| tx_data_o | output | 12 | Data bus to the DAC |
| tx_sel_o | output | 1 | Channel select, 1 for I |

## Verification
The assertions assume that sample and underflow inputs change only between clock edges. They also assume that the datapath holds its I and Q values steady when a request edge arrives. The bench drives every input on the falling edge and samples every output there too, so each request edge sees settled data. The bench changes q_data_i during the I cycle on purpose. This shows that the Q word comes from the captured sample and not from the live input. Underflow is raised only on selected request edges.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  // bus phase inside one sample period
  typedef enum logic {
    PH_I = 1'b0,  // smp clock low; I word on bus next cycle is not yet taken
    PH_Q = 1'b1   // smp clock high; request edge ends this cycle
  } phase_e;
endpackage

// File: rtl/tx_clk_div.sv
module tx_clk_div
  import dac_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e ph_o,
  output logic   smp_clk_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_I;
    else         ph_q <= (ph_q == PH_I) ? PH_Q : PH_I;
  end

  assign ph_o      = ph_q;
  assign smp_clk_o = (ph_q == PH_Q);
endmodule

// File: rtl/tx_sync_gate.sv
module tx_sync_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic run_o
);
  logic run_q;

  // sticky: first sync after reset starts transmission
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b0;
    else if (sync_i) run_q <= 1'b1;
  end

  assign run_o = run_q;
endmodule

// File: rtl/tx_word_mux.sv
module tx_word_mux
  import dac_tx_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           ph_i,
  input  logic             run_i,
  input  logic             underflow_i,
  input  logic [IN_W-1:0]  i_data_i,
  input  logic [IN_W-1:0]  q_data_i,
  output logic             req_o,
  output logic [OUT_W-1:0] tx_data_o,
  output logic             tx_sel_o
);
  localparam int MSB = IN_W - 1;

  logic [OUT_W-1:0] hold_q;
  logic [OUT_W-1:0] data_q;
  logic             sel_q;
  logic             take;
  logic [OUT_W-1:0] i_trunc;
  logic [OUT_W-1:0] q_trunc;

  assign take    = run_i && (ph_i == PH_Q);
  assign i_trunc = underflow_i ? '0 : i_data_i[MSB -: OUT_W];
  assign q_trunc = underflow_i ? '0 : q_data_i[MSB -: OUT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      data_q <= '0;
      sel_q  <= 1'b0;
    end else if (ph_i == PH_Q) begin
      sel_q <= 1'b1;
      if (take) begin
        data_q <= i_trunc;
        hold_q <= q_trunc;
      end else begin
        data_q <= '0;
      end
    end else begin
      sel_q  <= 1'b0;
      data_q <= hold_q;
    end
  end

  assign req_o     = take;
  assign tx_data_o = data_q;
  assign tx_sel_o  = sel_q;
endmodule

// File: rtl/dac_tx_if.sv
module dac_tx_if
  import dac_tx_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             underflow_i,
  input  logic [IN_W-1:0]  i_data_i,
  input  logic [IN_W-1:0]  q_data_i,
  output logic             smp_clk_o,
  output logic             i_en_o,
  output logic             q_en_o,
  output logic             i_req_o,
  output logic             q_req_o,
  output logic [OUT_W-1:0] tx_data_o,
  output logic             tx_sel_o
);
  phase_e ph;
  logic   run;
  logic   req;

  tx_clk_div u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph_o      (ph),
    .smp_clk_o (smp_clk_o)
  );

  tx_sync_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .run_o  (run)
  );

  tx_word_mux #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ph_i        (ph),
    .run_i       (run),
    .underflow_i (underflow_i),
    .i_data_i    (i_data_i),
    .q_data_i    (q_data_i),
    .req_o       (req),
    .tx_data_o   (tx_data_o),
    .tx_sel_o    (tx_sel_o)
  );

  assign i_en_o  = run;
  assign q_en_o  = run;
  assign i_req_o = req;
  assign q_req_o = req;
endmodule

// File: rtl/dac_tx_if_chk.sv
module dac_tx_if_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             underflow_i,
  input logic [IN_W-1:0]  i_data_i,
  input logic [IN_W-1:0]  q_data_i,
  input logic             smp_clk_o,
  input logic             i_en_o,
  input logic             q_en_o,
  input logic             i_req_o,
  input logic             q_req_o,
  input logic [OUT_W-1:0] tx_data_o,
  input logic             tx_sel_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R2
  clk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    smp_clk_o != $past(smp_clk_o));
  // R3
  sel_i_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_clk_o |=> tx_sel_o);
  // R3
  sel_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !smp_clk_o |=> !tx_sel_o);
  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !i_en_o |-> (tx_data_o == '0 && !i_req_o && !q_req_o));
  // R5
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_en_o && q_en_o) |=> (i_en_o && q_en_o));
  // R6
  req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_req_o || q_req_o) |-> (smp_clk_o && i_en_o));
  // R7
  i_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_req_o && !underflow_i) |=> tx_data_o == $past(i_data_i[IN_W-1 -: OUT_W]));
  // R8
  q_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_req_o && !underflow_i) |-> ##2 tx_data_o == $past(q_data_i[IN_W-1 -: OUT_W], 2));
  // R9
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_req_o && underflow_i) |=> tx_data_o == '0);
endmodule

bind dac_tx_if dac_tx_if_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_i),
  .underflow_i (underflow_i),
  .i_data_i    (i_data_i),
  .q_data_i    (q_data_i),
  .smp_clk_o   (smp_clk_o),
  .i_en_o      (i_en_o),
  .q_en_o      (q_en_o),
  .i_req_o     (i_req_o),
  .q_req_o     (q_req_o),
  .tx_data_o   (tx_data_o),
  .tx_sel_o    (tx_sel_o)
);

// File: tb/sim_dac_tx_if.sv
module sim_dac_tx_if;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0;
  logic        underflow_i = 1'b0;
  logic [15:0] i_data_i = '0;
  logic [15:0] q_data_i = '0;
  logic        smp_clk_o, i_en_o, q_en_o, i_req_o, q_req_o, tx_sel_o;
  logic [11:0] tx_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dac_tx_if u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .underflow_i(underflow_i),
    .i_data_i(i_data_i), .q_data_i(q_data_i), .smp_clk_o(smp_clk_o),
    .i_en_o(i_en_o), .q_en_o(q_en_o), .i_req_o(i_req_o), .q_req_o(q_req_o),
    .tx_data_o(tx_data_o), .tx_sel_o(tx_sel_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic prev_clk;
    logic [15:0] iv, qv;
    logic uf;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({tx_data_o, tx_sel_o, smp_clk_o, i_req_o, q_req_o, i_en_o, q_en_o} == '0,
        "R1", {tx_data_o, tx_sel_o, smp_clk_o, i_req_o, q_req_o, i_en_o, q_en_o}, 0);
    rst_ni = 1'b1;
    i_data_i = 16'hffff;
    q_data_i = 16'hffff;
    chk(smp_clk_o == 1'b0, "R2", smp_clk_o, 0);
    prev_clk = smp_clk_o;
    // R4: no sync yet, outputs idle; R2/R3 phase behaviour
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(smp_clk_o != prev_clk, "R2", smp_clk_o, !prev_clk);
      chk(tx_sel_o == prev_clk, "R3", tx_sel_o, prev_clk);
      chk(tx_data_o == 0 && !i_req_o && !q_req_o && !i_en_o && !q_en_o,
          "R4", {tx_data_o, i_req_o, q_req_o, i_en_o, q_en_o}, 0);
      prev_clk = smp_clk_o;
    end
    // R5: one-cycle sync pulse
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    chk(i_en_o && q_en_o, "R5", {i_en_o, q_en_o}, 3);
    // sweep samples
    for (int s = 0; s < 400; s++) begin
      if (!i_req_o) begin
        chk(!q_req_o && !smp_clk_o, "R6", {i_req_o, q_req_o, smp_clk_o}, 0);
        @(negedge clk);
      end
      chk(i_req_o && q_req_o && smp_clk_o, "R6", {i_req_o, q_req_o, smp_clk_o}, 7);
      iv = 16'((s * 4099 + 17) & 16'hffff);
      qv = 16'((s * 40503 + 5) & 16'hffff);
      if (s == 0) begin iv = 16'h000f; qv = 16'hfff0; end
      if (s == 1) begin iv = 16'hffff; qv = 16'h0000; end
      uf = (s % 7) == 3;
      i_data_i = iv;
      q_data_i = qv;
      underflow_i = uf;
      @(negedge clk);
      // corrupt live inputs: Q must come from the captured sample
      i_data_i = ~iv;
      q_data_i = ~qv;
      underflow_i = 1'b0;
      chk(tx_sel_o == 1'b1, "R3", tx_sel_o, 1);
      chk(!i_req_o && !smp_clk_o, "R6", {i_req_o, smp_clk_o}, 0);
      if (uf) chk(tx_data_o == 0, "R9", tx_data_o, 0);
      else    chk(tx_data_o == iv[15:4], "R7", tx_data_o, iv[15:4]);
      @(negedge clk);
      chk(tx_sel_o == 1'b0, "R3", tx_sel_o, 0);
      if (uf) chk(tx_data_o == 0, "R9", tx_data_o, 0);
      else    chk(tx_data_o == qv[15:4], "R8", tx_data_o, qv[15:4]);
      chk(i_en_o && q_en_o, "R5", {i_en_o, q_en_o}, 3);
    end
    finish_run();
  end
endmodule